// File: doc/BRIEF.md
# Intercluster Writeback Resource Arbiter

This block decides which function units may write results into register files. Every unit belongs to a home cluster and may aim its result at any cluster. A unit asks in the cycle it updates the destination scoreboard, which is two cycles before its result exists. The arbiter answers in that same cycle. It either grants everything the transfer needs at once, or it tells the unit to stall. A stalled unit keeps its request and destination unchanged and asks again on every following cycle. There is never a partial or multi-round grant, so units cannot hold some resources while they wait for others.

Each unit owns its outgoing network path. The scarce resource is therefore the write ports of the destination register file in the cycle the value lands. A write to the unit's own cluster lands two cycles after the grant. A write to another cluster uses the unit's path two cycles after the grant and lands one cycle later, after the one-cycle network hop. A table of port reservations, kept per future landing cycle, makes sure that a later request cannot take a port that an earlier grant already holds for the same cycle. Among requests made in the same cycle, the lower unit index is served first.

Top module: `xcl_wb_arbiter`

## Requirements
- R1: The grant or stall decision for a request appears in the cycle the request is presented. `sb_upd[c]` is high in that cycle exactly when at least one unit is granted a write into cluster c.
- R2: For each destination cluster and each landing cycle, at most PORTS writes are granted. Among requests made in the same cycle, the lower unit index is served first.
- R3: A granted unit gets the lowest-numbered port of its destination that is free in its landing cycle. The port of unit i is reported in `gnt_port[i*PW +: PW]`.
- R4: A remote write is one whose destination differs from the unit's home cluster, i / UPC. If it is granted in cycle t, `path_drive[i]` is high in cycle t+2 only, and `wp_en[dst*PORTS+port]` is high in cycle t+3 only.
- R5: If a local write is granted in cycle t, `wp_en[dst*PORTS+port]` is high in cycle t+2 and `path_drive[i]` stays low.
- R6: A port reserved by an earlier grant for a given landing cycle is never handed to a later request that lands in the same cycle. Such a request loses when no other port of that cluster is free.
- R7: `stall[i]` is high exactly when unit i requests and is not granted, so `gnt` and `stall` never overlap. A held request is granted once a port frees.
- R8: While `rst` is high, no grant, stall, path or port-enable output is driven, and reset clears all reservations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | N_UNITS | Per-unit request for a writeback slot |
| req_dst | input | N_UNITS*CW | Destination cluster of each unit, unit i at bits [i*CW +: CW] |
| gnt | output | N_UNITS | Grant in the request cycle |
| stall | output | N_UNITS | Request refused this cycle; the unit holds and retries |
| gnt_port | output | N_UNITS*PW | Destination write port given to each granted unit |
| sb_upd | output | N_CL | Scoreboard-update strobe per destination cluster |
| path_drive | output | N_UNITS | Unit drives its network path this cycle (remote writes) |
| wp_en | output | N_CL*PORTS | Write-port enable per cluster port in the landing cycle |

## Verification
Single remote and single local requests separate the two landing delays and show whether the path strobe appears only for remote writes. Several units aimed at one cluster in the same cycle test the per-cluster port limit, the index priority and the port numbering. An all-units burst at one cluster shows that local and remote landings are counted in separate cycles. A remote grant followed one cycle later by local requests that land in the same cycle shows whether older reservations are respected. The held retries that follow each refusal confirm that a stalled unit wins once its port frees.

// File: rtl/wbarb_pkg.sv
package wbarb_pkg;
  localparam int DEF_UNITS = 8;
  localparam int DEF_CL    = 4;
  localparam int DEF_PORTS = 2;
  localparam int DEF_UPC   = 2;
  localparam int DEF_LEAD  = 2;
  localparam int DEF_XFER  = 1;

  // index width that stays at least one bit
  function automatic int idx_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  typedef enum logic {
    LAND_NEAR = 1'b0,
    LAND_FAR  = 1'b1
  } land_e;
endpackage

// File: rtl/wbarb_alloc.sv
// Single-pass fixed-priority allocator: every request gets all it needs or nothing.
module wbarb_alloc
  import wbarb_pkg::*;
#(
  parameter int N_UNITS = DEF_UNITS,
  parameter int N_CL    = DEF_CL,
  parameter int PORTS   = DEF_PORTS,
  parameter int UPC     = DEF_UPC,
  localparam int CW = idx_w(N_CL),
  localparam int PW = idx_w(PORTS),
  localparam int NP = N_CL * PORTS
) (
  input  logic [N_UNITS-1:0]    req_vld,
  input  logic [N_UNITS*CW-1:0] req_dst,
  input  logic [NP-1:0]         busy_near,
  output logic [N_UNITS-1:0]    gnt,
  output logic [N_UNITS-1:0]    gnt_far,
  output logic [N_UNITS*PW-1:0] gnt_port,
  output logic [NP-1:0]         claim_near,
  output logic [NP-1:0]         claim_far
);
  logic [NP-1:0] taken_near;
  logic [NP-1:0] taken_far;
  int            dst;
  land_e         kind;
  logic          hit;
  logic          occ;
  logic [PW-1:0] pick;

  always_comb begin
    taken_near = busy_near;
    taken_far  = '0;
    gnt        = '0;
    gnt_far    = '0;
    gnt_port   = '0;
    dst        = 0;
    kind       = LAND_NEAR;
    hit        = 1'b0;
    occ        = 1'b0;
    pick       = '0;
    for (int i = 0; i < N_UNITS; i++) begin
      dst  = int'(req_dst[i*CW +: CW]);
      kind = (dst == i / UPC) ? LAND_NEAR : LAND_FAR;
      hit  = 1'b0;
      pick = '0;
      if (req_vld[i] && dst < N_CL) begin
        for (int p = 0; p < PORTS; p++) begin
          occ = (kind == LAND_FAR) ? taken_far[dst*PORTS + p]
                                   : taken_near[dst*PORTS + p];
          if (!hit && !occ) begin
            hit  = 1'b1;
            pick = PW'(p);
          end
        end
        if (hit) begin
          gnt[i]                = 1'b1;
          gnt_far[i]            = (kind == LAND_FAR);
          gnt_port[i*PW +: PW]  = pick;
          if (kind == LAND_FAR) taken_far[dst*PORTS + int'(pick)]  = 1'b1;
          else                  taken_near[dst*PORTS + int'(pick)] = 1'b1;
        end
      end
    end
    claim_near = taken_near & ~busy_near;
    claim_far  = taken_far;
  end
endmodule

// File: rtl/wbarb_res_table.sv
// Port reservations per future landing cycle; slot k holds landings k cycles ahead.
module wbarb_res_table #(
  parameter int N_CL  = 4,
  parameter int PORTS = 2,
  parameter int LEAD  = 2,
  parameter int XFER  = 1,
  localparam int DEPTH = LEAD + XFER,
  localparam int W     = N_CL * PORTS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] claim_near,
  input  logic [W-1:0] claim_far,
  output logic [W-1:0] busy_near,
  output logic [W-1:0] port_now
);
  logic [W-1:0] slot [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    logic [W-1:0] carry;
    logic [W-1:0] add;
    if (k == DEPTH - 1) begin : g_top
      assign carry = '0;
    end else begin : g_mid
      assign carry = slot[k+1];
    end
    assign add = ((k + 1 == LEAD) ? claim_near : '0) |
                 ((k + 1 == LEAD + XFER) ? claim_far : '0);
    always_ff @(posedge clk) begin
      if (rst) slot[k] <= '0;
      else     slot[k] <= carry | add;
    end
  end

  assign busy_near = slot[LEAD];
  assign port_now  = slot[0];
endmodule

// File: rtl/wbarb_delay.sv
// Fixed-length delay line for per-unit strobes.
module wbarb_delay #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic [W-1:0] src;
    if (s == 0) begin : g_first
      assign src = din;
    end else begin : g_next
      assign src = stg[s-1];
    end
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= src;
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/xcl_wb_arbiter.sv
module xcl_wb_arbiter
  import wbarb_pkg::*;
#(
  parameter int N_UNITS = DEF_UNITS,
  parameter int N_CL    = DEF_CL,
  parameter int PORTS   = DEF_PORTS,
  parameter int UPC     = DEF_UPC,
  parameter int LEAD    = DEF_LEAD,
  parameter int XFER    = DEF_XFER,
  localparam int CW = idx_w(N_CL),
  localparam int PW = idx_w(PORTS),
  localparam int NP = N_CL * PORTS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_UNITS-1:0]    req_vld,
  input  logic [N_UNITS*CW-1:0] req_dst,
  output logic [N_UNITS-1:0]    gnt,
  output logic [N_UNITS-1:0]    stall,
  output logic [N_UNITS*PW-1:0] gnt_port,
  output logic [N_CL-1:0]       sb_upd,
  output logic [N_UNITS-1:0]    path_drive,
  output logic [NP-1:0]         wp_en
);
  logic [N_UNITS-1:0] req_live;
  logic [N_UNITS-1:0] gnt_far;
  logic [NP-1:0]      busy_near;
  logic [NP-1:0]      claim_near;
  logic [NP-1:0]      claim_far;

  assign req_live = rst ? '0 : req_vld;

  wbarb_alloc #(
    .N_UNITS(N_UNITS), .N_CL(N_CL), .PORTS(PORTS), .UPC(UPC)
  ) alloc_i (
    .req_vld   (req_live),
    .req_dst   (req_dst),
    .busy_near (busy_near),
    .gnt       (gnt),
    .gnt_far   (gnt_far),
    .gnt_port  (gnt_port),
    .claim_near(claim_near),
    .claim_far (claim_far)
  );

  wbarb_res_table #(
    .N_CL(N_CL), .PORTS(PORTS), .LEAD(LEAD), .XFER(XFER)
  ) table_i (
    .clk       (clk),
    .rst       (rst),
    .claim_near(claim_near),
    .claim_far (claim_far),
    .busy_near (busy_near),
    .port_now  (wp_en)
  );

  wbarb_delay #(
    .W(N_UNITS), .STAGES(LEAD)
  ) path_i (
    .clk (clk),
    .rst (rst),
    .din (gnt_far),
    .dout(path_drive)
  );

  assign stall = req_live & ~gnt;

  always_comb begin
    sb_upd = '0;
    for (int i = 0; i < N_UNITS; i++) begin
      if (gnt[i] && int'(req_dst[i*CW +: CW]) < N_CL)
        sb_upd[int'(req_dst[i*CW +: CW])] = 1'b1;
    end
  end
endmodule

// File: rtl/xcl_wb_arbiter_chk.sv
module xcl_wb_arbiter_chk
  import wbarb_pkg::*;
#(
  parameter int N_UNITS = DEF_UNITS,
  parameter int N_CL    = DEF_CL,
  parameter int PORTS   = DEF_PORTS,
  parameter int UPC     = DEF_UPC,
  localparam int CW = idx_w(N_CL)
) (
  input logic                  clk,
  input logic                  rst,
  input logic [N_UNITS-1:0]    req_vld,
  input logic [N_UNITS*CW-1:0] req_dst,
  input logic [N_UNITS-1:0]    gnt,
  input logic [N_UNITS-1:0]    stall,
  input logic [N_CL-1:0]       sb_upd,
  input logic [N_UNITS-1:0]    path_drive
);
  logic [N_CL-1:0] seen_cl;
  int              n_near [N_CL];
  int              n_far  [N_CL];

  always_comb begin
    seen_cl = '0;
    for (int c = 0; c < N_CL; c++) begin
      n_near[c] = 0;
      n_far[c]  = 0;
      for (int i = 0; i < N_UNITS; i++) begin
        if (gnt[i] && int'(req_dst[i*CW +: CW]) == c) begin
          seen_cl[c] = 1'b1;
          if (c == i / UPC) n_near[c] = n_near[c] + 1;
          else              n_far[c]  = n_far[c] + 1;
        end
      end
    end
  end

  // R7
  gnt_stall_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ((gnt & stall) == '0) && ((gnt | stall) == req_vld));

  for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
      stall[i] |=> (req_vld[i] && $stable(req_dst[i*CW +: CW])));
    // R4
    path_lag_chk: assert property (@(posedge clk) disable iff (rst)
      path_drive[i] |-> $past(gnt[i], 2));
  end

  for (genvar c = 0; c < N_CL; c++) begin : g_cl
    // R1
    sb_src_chk: assert property (@(posedge clk) disable iff (rst)
      sb_upd[c] == seen_cl[c]);
    // R2
    port_cap_chk: assert property (@(posedge clk) disable iff (rst)
      (n_near[c] <= PORTS) && (n_far[c] <= PORTS));
  end
endmodule

bind xcl_wb_arbiter xcl_wb_arbiter_chk #(
  .N_UNITS(N_UNITS), .N_CL(N_CL), .PORTS(PORTS), .UPC(UPC)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_vld   (req_vld),
  .req_dst   (req_dst),
  .gnt       (gnt),
  .stall     (stall),
  .sb_upd    (sb_upd),
  .path_drive(path_drive)
);

// File: tb/xcl_wb_arbiter_tb_top.sv
module xcl_wb_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NU    = 8;
  localparam int NC    = 4;
  localparam int NP    = 2;
  localparam int UPC   = 2;
  localparam int CW    = 2;
  localparam int PW    = 1;
  localparam int WATCH = 5000;

  logic              clk = 1'b0;
  logic              rst;
  logic [NU-1:0]     req_vld;
  logic [NU*CW-1:0]  req_dst;
  logic [NU-1:0]     gnt;
  logic [NU-1:0]     stall;
  logic [NU*PW-1:0]  gnt_port;
  logic [NC-1:0]     sb_upd;
  logic [NU-1:0]     path_drive;
  logic [NC*NP-1:0]  wp_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcl_wb_arbiter #(
    .N_UNITS(NU), .N_CL(NC), .PORTS(NP), .UPC(UPC), .LEAD(2), .XFER(1)
  ) dut_i (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_dst(req_dst),
    .gnt(gnt), .stall(stall), .gnt_port(gnt_port), .sb_upd(sb_upd),
    .path_drive(path_drive), .wp_en(wp_en)
  );

  typedef struct {
    int at;
    bit is_path;
    int bitpos;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_req();
    req_vld = '0;
    req_dst = '0;
  endtask

  task automatic put(input int u, input int d);
    req_vld[u] = 1'b1;
    req_dst[u*CW +: CW] = CW'(d);
  endtask

  // check one unit's answer and queue what must follow at the ports
  task automatic expect_unit(input int u, input bit g, input int p, input string req);
    int  d;
    bit  far;
    exp_t e;
    d   = int'(req_dst[u*CW +: CW]);
    far = (d != u / UPC);
    chk(gnt[u] == g, req, $sformatf("gnt[%0d]", u), int'(gnt[u]), int'(g));
    chk(stall[u] == (req_vld[u] && !g), "R7", $sformatf("stall[%0d]", u),
        int'(stall[u]), int'(req_vld[u] && !g));
    if (g) begin
      chk(int'(gnt_port[u*PW +: PW]) == p, "R3", $sformatf("port[%0d]", u),
          int'(gnt_port[u*PW +: PW]), p);
      e.at = cyc + (far ? 3 : 2); e.is_path = 1'b0; e.bitpos = d*NP + p;
      q.push_back(e);
      if (far) begin
        e.at = cyc + 2; e.is_path = 1'b1; e.bitpos = u;
        q.push_back(e);
      end
    end
  endtask

  task automatic expect_sb(input logic [NC-1:0] m, input string req);
    chk(sb_upd == m, req, "sb_upd", int'(sb_upd), int'(m));
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      clear_req();
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // monitor: compares delayed strobes against queued expectations (R4, R5, R8)
  always @(negedge clk) begin
    logic [NC*NP-1:0] ew;
    logic [NU-1:0]    ep;
    ew = '0;
    ep = '0;
    for (int k = q.size() - 1; k >= 0; k--) begin
      if (q[k].at == cyc) begin
        if (q[k].is_path) ep[q[k].bitpos] = 1'b1;
        else              ew[q[k].bitpos] = 1'b1;
        q.delete(k);
      end else if (q[k].at < cyc) begin
        chk(1'b0, "R4", "stale expectation", q[k].at, cyc);
        q.delete(k);
      end
    end
    chk(wp_en == ew, "R4 R5", $sformatf("wp_en at cycle %0d", cyc), int'(wp_en), int'(ew));
    chk(path_drive == ep, "R4 R5", $sformatf("path_drive at cycle %0d", cyc),
        int'(path_drive), int'(ep));
  end

  initial begin
    rst = 1'b1;
    clear_req();
    repeat (3) @(negedge clk);
    // R8: requests during reset are ignored
    put(0, 1);
    put(3, 1);
    #1;
    chk(gnt == '0, "R8", "gnt in reset", int'(gnt), 0);
    chk(stall == '0, "R8", "stall in reset", int'(stall), 0);
    chk(sb_upd == '0, "R8", "sb_upd in reset", int'(sb_upd), 0);
    @(negedge clk);
    clear_req();
    rst = 1'b0;
    idle(3);

    // R1 R4: one remote write
    @(negedge clk); clear_req(); put(0, 1); #1;
    expect_unit(0, 1'b1, 0, "R1"); expect_sb(4'b0010, "R1");
    idle(5);

    // R5: one local write
    @(negedge clk); clear_req(); put(3, 1); #1;
    expect_unit(3, 1'b1, 0, "R5"); expect_sb(4'b0010, "R1");
    idle(5);

    // R2 R3: three units to one cluster, then the loser retries
    @(negedge clk); clear_req(); put(0, 2); put(2, 2); put(6, 2); #1;
    expect_unit(0, 1'b1, 0, "R2"); expect_unit(2, 1'b1, 1, "R3");
    expect_unit(6, 1'b0, 0, "R2"); expect_sb(4'b0100, "R1");
    @(negedge clk); clear_req(); put(6, 2); #1;
    expect_unit(6, 1'b1, 0, "R7");
    idle(5);

    // R6: earlier remote grants hold both ports for the local landing cycle
    @(negedge clk); clear_req(); put(0, 2); put(2, 2); #1;
    expect_unit(0, 1'b1, 0, "R4"); expect_unit(2, 1'b1, 1, "R3");
    @(negedge clk); clear_req(); put(4, 2); put(5, 2); #1;
    expect_unit(4, 1'b0, 0, "R6"); expect_unit(5, 1'b0, 0, "R6");
    expect_sb(4'b0000, "R1");
    @(negedge clk); clear_req(); put(4, 2); put(5, 2); #1;
    expect_unit(4, 1'b1, 0, "R7"); expect_unit(5, 1'b1, 1, "R7");
    idle(5);

    // R3 R6: one port left by an earlier remote grant goes to the first local request
    @(negedge clk); clear_req(); put(0, 3); #1;
    expect_unit(0, 1'b1, 0, "R4");
    @(negedge clk); clear_req(); put(6, 3); put(7, 3); #1;
    expect_unit(6, 1'b1, 1, "R3"); expect_unit(7, 1'b0, 0, "R6");
    @(negedge clk); clear_req(); put(7, 3); #1;
    expect_unit(7, 1'b1, 0, "R7");
    idle(5);

    // R2: every unit aims at cluster 0; local and remote land in different cycles
    @(negedge clk); clear_req();
    for (int u = 0; u < NU; u++) put(u, 0);
    #1;
    expect_unit(0, 1'b1, 0, "R2"); expect_unit(1, 1'b1, 1, "R2");
    expect_unit(2, 1'b1, 0, "R2"); expect_unit(3, 1'b1, 1, "R2");
    for (int u = 4; u < NU; u++) expect_unit(u, 1'b0, 0, "R2");
    expect_sb(4'b0001, "R1");
    @(negedge clk); clear_req();
    for (int u = 4; u < NU; u++) put(u, 0);
    #1;
    expect_unit(4, 1'b1, 0, "R2"); expect_unit(5, 1'b1, 1, "R2");
    expect_unit(6, 1'b0, 0, "R2"); expect_unit(7, 1'b0, 0, "R2");
    @(negedge clk); clear_req(); put(6, 0); put(7, 0); #1;
    expect_unit(6, 1'b1, 0, "R7"); expect_unit(7, 1'b1, 1, "R7");
    idle(5);

    // R1 R7: idle cycle answers nothing
    @(negedge clk); clear_req(); #1;
    chk(gnt == '0, "R1", "idle gnt", int'(gnt), 0);
    chk(stall == '0, "R7", "idle stall", int'(stall), 0);
    expect_sb(4'b0000, "R1");
    idle(4);

    chk(q.size() == 0, "R4", "pending expectations", q.size(), 0);
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (WATCH) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCH, 0);
      report();
      $finish;
    end
  end
endmodule